// File: doc/BRIEF.md
# Clock Request Output Gating

This block decides, every clock, which clock outputs of a clock generator are running. It covers six general-purpose differential outputs, two auxiliary differential outputs, three CPU differential pairs and five single-ended outputs. For each differential output it produces an enable flag, and a flag that says the disabled output must go to high impedance rather than be driven. The register fields that control the gating arrive as plain input vectors, held by a register file outside this block.

Each general-purpose output can follow either of two active-low request pins. The choice is made by two separate select masks. A per-output master enable overrides any request. A CPU stop pin halts the CPU pairs, but only those whose stoppable bit is set. The request pins and the stop pin are asynchronous, so each passes through a two-flop synchronizer before it is used. If both masks are set for the same output, that output runs only while both request pins are low, and a sticky conflict flag records the event.

General-purpose lane i (0 to 5) drives physical outputs 0, 3, 4, 5, 6 and 7, in that order. Single-ended bits are assigned as follows: bit 0 is the PCI clock, bit 1 is the USB clock, and bits 2 to 4 are the three reference clocks.

Top module: `clk_req_gate`

## Requirements
- R1: A change on req_a_n, req_b_n or cpu_stop_n affects the outputs exactly two rising clock edges after it is applied. Register-field inputs act within the same cycle.
- R2: A general-purpose output whose only select bit is the A mask runs while the synchronized req_a_n is 0 and stops while it is 1. The B mask gives the same behaviour against req_b_n.
- R3: A general-purpose output with neither select bit set runs whenever its master enable is 1, whatever the request pins do.
- R4: A general-purpose output whose master enable is 0 is off, whatever its select bits and the request pins are.
- R5: With both select bits set, an output runs only while both synchronized request pins are 0. sel_conflict rises on the clock edge after any such overlap is seen and stays at 1 until reset.
- R6: aux_on equals aux_en, and the request and stop pins have no effect on it.
- R7: cpu_on[i] is 1 when cpu_en[i] is 1 and either the synchronized cpu_stop_n is 1 or cpu_stoppable[i] is 0. Otherwise cpu_on[i] is 0.
- R8: For every differential output, the hiz flag is 1 exactly when that output is off and dis_hiz is 1. With dis_hiz at 0, all hiz flags are 0.
- R9: se_on equals se_en.
- R10: During reset and for the first two edges after it, the synchronizers read both request pins as 1 and the stop pin as 1. sel_conflict is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a_n | input | 1 | Request pin A, active low, asynchronous |
| req_b_n | input | 1 | Request pin B, active low, asynchronous |
| cpu_stop_n | input | 1 | CPU stop pin, active low, asynchronous |
| gp_master_en | input | 6 | Master enable per general-purpose lane |
| gp_sel_a | input | 6 | Lane follows request pin A |
| gp_sel_b | input | 6 | Lane follows request pin B |
| aux_en | input | 2 | Auxiliary output enables |
| cpu_en | input | 3 | CPU pair enables |
| cpu_stoppable | input | 3 | 1: pair halts on stop; 0: free-running |
| dis_hiz | input | 1 | Disabled differential outputs: 0 driven, 1 high impedance |
| se_en | input | 5 | Single-ended enables |
| gp_on | output | 6 | General-purpose lane running |
| gp_hiz | output | 6 | General-purpose lane off in high impedance |
| aux_on | output | 2 | Auxiliary output running |
| aux_hiz | output | 2 | Auxiliary output off in high impedance |
| cpu_on | output | 3 | CPU pair running |
| cpu_hiz | output | 3 | CPU pair off in high impedance |
| se_on | output | 5 | Single-ended output running |
| sel_conflict | output | 1 | Sticky flag: some lane had both masks set |

## Verification
The hardest state to reach is a lane with both select bits set while the two request pins are in opposite states. To observe it, the sticky conflict flag must still be clear just before the overlap first appears. The stimulus therefore runs a first random phase in which the B mask is always drawn disjoint from the A mask. A second phase then allows overlap, and a directed step forces lane 0 into the overlapping state with the pins split. The reference model delays the pin values by two steps, so every check compares against the synchronized view, and the two-cycle latency is measured at every step.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int unsigned GP_LANES  = 6;
  localparam int unsigned AUX_LANES = 2;
  localparam int unsigned CPU_LANES = 3;
  localparam int unsigned SE_LANES  = 5;
  localparam int unsigned SYNC_LEN  = 2;

  // Request qualification for one lane; pin arguments are active-high "asserted".
  function automatic logic req_grant(logic sel_a, logic sel_b,
                                     logic a_act, logic b_act);
    logic g;
    unique case ({sel_a, sel_b})
      2'b00:   g = 1'b1;
      2'b10:   g = a_act;
      2'b01:   g = b_act;
      default: g = a_act & b_act;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[k] <= '1;
        else        stg_q[k] <= stg_d[k];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cg_gp_lanes.sv
module cg_gp_lanes
  import clkgate_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] master_en,
  input  logic [N-1:0] sel_a,
  input  logic [N-1:0] sel_b,
  input  logic         a_act,
  input  logic         b_act,
  input  logic         hiz_mode,
  output logic [N-1:0] on,
  output logic [N-1:0] hiz,
  output logic         overlap
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      always_comb begin
        on[i]  = master_en[i] & req_grant(sel_a[i], sel_b[i], a_act, b_act);
        hiz[i] = ~on[i] & hiz_mode;
      end
    end
  endgenerate

  assign overlap = |(sel_a & sel_b);
endmodule

// File: rtl/cg_cpu_lanes.sv
module cg_cpu_lanes #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] stoppable,
  input  logic         stop_act,
  input  logic         hiz_mode,
  output logic [N-1:0] on,
  output logic [N-1:0] hiz
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      always_comb begin
        on[i]  = en[i] & ~(stoppable[i] & stop_act);
        hiz[i] = ~on[i] & hiz_mode;
      end
    end
  endgenerate
endmodule

// File: rtl/clk_req_gate.sv
module clk_req_gate
  import clkgate_pkg::*;
#(
  parameter int unsigned NGP  = GP_LANES,
  parameter int unsigned NAUX = AUX_LANES,
  parameter int unsigned NCPU = CPU_LANES,
  parameter int unsigned NSE  = SE_LANES,
  parameter int unsigned SYNC = SYNC_LEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_a_n,
  input  logic            req_b_n,
  input  logic            cpu_stop_n,
  input  logic [NGP-1:0]  gp_master_en,
  input  logic [NGP-1:0]  gp_sel_a,
  input  logic [NGP-1:0]  gp_sel_b,
  input  logic [NAUX-1:0] aux_en,
  input  logic [NCPU-1:0] cpu_en,
  input  logic [NCPU-1:0] cpu_stoppable,
  input  logic            dis_hiz,
  input  logic [NSE-1:0]  se_en,
  output logic [NGP-1:0]  gp_on,
  output logic [NGP-1:0]  gp_hiz,
  output logic [NAUX-1:0] aux_on,
  output logic [NAUX-1:0] aux_hiz,
  output logic [NCPU-1:0] cpu_on,
  output logic [NCPU-1:0] cpu_hiz,
  output logic [NSE-1:0]  se_on,
  output logic            sel_conflict
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pin_raw, pin_sync;
  logic            overlap;
  logic            conflict_d, conflict_q;

  assign pin_raw = {cpu_stop_n, req_b_n, req_a_n};

  cg_sync #(.W(NPIN), .STAGES(SYNC)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sync)
  );

  cg_gp_lanes #(.N(NGP)) i_gp (
    .master_en(gp_master_en), .sel_a(gp_sel_a), .sel_b(gp_sel_b),
    .a_act(~pin_sync[0]), .b_act(~pin_sync[1]), .hiz_mode(dis_hiz),
    .on(gp_on), .hiz(gp_hiz), .overlap(overlap)
  );

  cg_cpu_lanes #(.N(NCPU)) i_cpu (
    .en(cpu_en), .stoppable(cpu_stoppable), .stop_act(~pin_sync[2]),
    .hiz_mode(dis_hiz), .on(cpu_on), .hiz(cpu_hiz)
  );

  always_comb begin
    aux_on  = aux_en;
    aux_hiz = ~aux_en & {NAUX{dis_hiz}};
    se_on   = se_en;
  end

  always_comb conflict_d = conflict_q | overlap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict_q <= 1'b0;
    else        conflict_q <= conflict_d;
  end

  assign sel_conflict = conflict_q;

  // R4
  gp_master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_on & ~gp_master_en) == '0);
  // R5
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_conflict |=> sel_conflict);
  // R5
  conflict_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gp_sel_a & gp_sel_b)) |=> sel_conflict);
  // R6
  aux_pin_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(aux_en) && $stable(dis_hiz)) |-> ($stable(aux_on) && $stable(aux_hiz)));
  // R7
  cpu_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en & ~cpu_stoppable & ~cpu_on) == '0);
  // R8
  hiz_off_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gp_hiz & gp_on) == '0) && ((cpu_hiz & cpu_on) == '0) && ((aux_hiz & aux_on) == '0));
  // R8
  hiz_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_hiz |-> (gp_hiz == '0 && cpu_hiz == '0 && aux_hiz == '0));
endmodule

// File: tb/test_clk_req_gate.sv
module test_clk_req_gate;
  localparam int NGP = 6, NAUX = 2, NCPU = 3, NSE = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_a_n, req_b_n, cpu_stop_n, dis_hiz;
  logic [NGP-1:0]  gp_master_en, gp_sel_a, gp_sel_b, gp_on, gp_hiz;
  logic [NAUX-1:0] aux_en, aux_on, aux_hiz;
  logic [NCPU-1:0] cpu_en, cpu_stoppable, cpu_on, cpu_hiz;
  logic [NSE-1:0]  se_en, se_on;
  logic            sel_conflict;

  clk_req_gate i_clk_req_gate (.*);

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NGP-1:0] ref_gp(logic [NGP-1:0] m, logic [NGP-1:0] sa,
                                            logic [NGP-1:0] sb, logic a_n, logic b_n);
    logic [NGP-1:0] r;
    for (int i = 0; i < NGP; i++) begin
      if (!m[i])                 r[i] = 1'b0;
      else if (sa[i] && sb[i])   r[i] = !a_n && !b_n;
      else if (sa[i])            r[i] = !a_n;
      else if (sb[i])            r[i] = !b_n;
      else                       r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NCPU-1:0] ref_cpu(logic [NCPU-1:0] e, logic [NCPU-1:0] s, logic stop_n);
    return e & (stop_n ? '1 : ~s);
  endfunction

  // pipeline view of the pins: p1 = one step ago, p2 = two steps ago
  logic p1a, p1b, p1s, p2a, p2b, p2s, c_exp;

  task automatic check_all(input string phase);
    logic [NGP-1:0] eg;
    logic [NCPU-1:0] ec;
    eg = ref_gp(gp_master_en, gp_sel_a, gp_sel_b, p2a, p2b);
    ec = ref_cpu(cpu_en, cpu_stoppable, p2s);
    chk({phase, " R1 R2 R3 R4 R5 gp_on"}, 16'(gp_on), 16'(eg));
    chk({phase, " R8 gp_hiz"}, 16'(gp_hiz), 16'(~eg & {NGP{dis_hiz}}));
    chk({phase, " R1 R7 cpu_on"}, 16'(cpu_on), 16'(ec));
    chk({phase, " R8 cpu_hiz"}, 16'(cpu_hiz), 16'(~ec & {NCPU{dis_hiz}}));
    chk({phase, " R6 aux_on"}, 16'(aux_on), 16'(aux_en));
    chk({phase, " R8 aux_hiz"}, 16'(aux_hiz), 16'(~aux_en & {NAUX{dis_hiz}}));
    chk({phase, " R9 se_on"}, 16'(se_on), 16'(se_en));
    chk({phase, " R5 sel_conflict"}, 16'(sel_conflict), 16'(c_exp));
  endtask

  task automatic step(input string phase);
    #1;
    check_all(phase);
    c_exp = c_exp | (|(gp_sel_a & gp_sel_b));
    p2a = p1a; p2b = p1b; p2s = p1s;
    p1a = req_a_n; p1b = req_b_n; p1s = cpu_stop_n;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0451));
    rst_n = 1'b0;
    req_a_n = 1'b0; req_b_n = 1'b0; cpu_stop_n = 1'b0; dis_hiz = 1'b1;
    gp_master_en = '1; gp_sel_a = 6'b000111; gp_sel_b = 6'b111000;
    aux_en = 2'b01; cpu_en = '1; cpu_stoppable = '1; se_en = 5'b10110;
    repeat (3) @(negedge clk);
    // R10: pins read as deasserted while in reset
    #1;
    chk("R10 gp_on in reset", 16'(gp_on), 16'h0);
    chk("R10 cpu_on in reset", 16'(cpu_on), 16'h7);
    chk("R10 sel_conflict in reset", 16'(sel_conflict), 16'h0);
    @(negedge clk);
    p1a = 1; p1b = 1; p1s = 1; p2a = 1; p2b = 1; p2s = 1; c_exp = 0;
    rst_n = 1'b1;
    // R1: low pins seen only after two edges
    step("R1 R10 post0");
    step("R1 R10 post1");
    step("R1 post2");
    // directed: free-running CPU pair during stop (R7)
    cpu_stoppable = 3'b101; dis_hiz = 1'b0;
    step("R7 free");
    // random phase 1: masks never overlap
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 3 == 0) req_a_n = $urandom;
      if ($urandom % 3 == 0) req_b_n = $urandom;
      if ($urandom % 4 == 0) cpu_stop_n = $urandom;
      gp_master_en = ($urandom % 4 == 0) ? 6'($urandom) : '1;
      gp_sel_a = 6'($urandom);
      gp_sel_b = 6'($urandom) & ~gp_sel_a;
      aux_en = 2'($urandom); cpu_en = 3'($urandom); cpu_stoppable = 3'($urandom);
      dis_hiz = $urandom; se_en = 5'($urandom);
      step("rand_disjoint");
    end
    // directed R5: overlap on lane 0 with pins split
    req_a_n = 1'b0; req_b_n = 1'b1; gp_master_en = '1;
    gp_sel_a = 6'b000001; gp_sel_b = 6'b000000;
    step("R5 pre");
    step("R5 pre");
    gp_sel_b = 6'b000001;
    step("R5 overlap split");
    gp_sel_b = 6'b000000;
    step("R5 sticky");
    req_b_n = 1'b0; gp_sel_b = 6'b000001;
    step("R5 both low");
    step("R5 both low");
    // random phase 2: overlap permitted
    for (int k = 0; k < 400; k++) begin
      req_a_n = ($urandom % 3 == 0) ? ~req_a_n : req_a_n;
      req_b_n = ($urandom % 3 == 0) ? ~req_b_n : req_b_n;
      cpu_stop_n = ($urandom % 4 == 0) ? ~cpu_stop_n : cpu_stop_n;
      gp_master_en = 6'($urandom) | 6'($urandom);
      gp_sel_a = 6'($urandom); gp_sel_b = 6'($urandom);
      aux_en = 2'($urandom); cpu_en = 3'($urandom); cpu_stoppable = 3'($urandom);
      dis_hiz = $urandom; se_en = 5'($urandom);
      step("rand_overlap");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule